// File: doc/BRIEF.md
# Mode-Configurable Four-Way Cache Tag Lookup

This block holds the tag store for one slice of a four-way set-associative cache and decides hit or miss for each lookup. A lookup presents a 36-bit physical address with a strobe. All four ways of the selected set are read and compared in parallel. One cycle later the block reports whether a way matched, which way it was, the line's coherence state, the pseudo-LRU victim way for that set and whether the two stored copies of the state disagreed.

A configuration input selects one of three capacity arrangements. In the small arrangement a line is 32 bytes and only half of the sets are used. In the medium arrangement a line is 16 bytes and every set is used. The large arrangement uses the medium geometry. In it, one address bit chooses which of two paired slices owns the access. That bit is left out of the tag compare, so the pair behaves like a single cache with twice the sets.

A write port fills a line, which writes the tag and both state copies. The same port can also change the state of a line that is already present. The coherence state is stored twice so that a soft error in either copy can be detected. The set count is a parameter, `IDX_W`. The defaults give 32 sets per way, a 27-bit tag from address bits 35..9, and the bank bit at address bit 10. Setting `IDX_W` to 13 gives the full-size slice: 8,192 sets, a 19-bit tag from bits 35..17, and the bank bit at bit 18.

Top module: `tagLookupTop`

## Requirements
- R1: A lookup that the slice serves produces `respValid` high for exactly one cycle, in the cycle after `reqValid`. No response appears without a served lookup, and consecutive lookups give consecutive responses.
- R2: A way hits when its stored tag equals the compared tag bits of the address and its primary state copy is not Invalid. MESI is coded as Invalid=0, Shared=1, Exclusive=2, Modified=3. On a hit, `respWay` gives the way and `respState` gives the primary state copy.
- R3: When no way hits, `respHit` is 0 and both `respWay` and `respState` are 0. This includes a way whose tag matches but whose state is Invalid.
- R4: With `cfgMode`=0 (small), the line is 32 bytes and the set index is `{0, addr[8:5]}`. Address bits 4..0 do not affect the result, and the upper half of the sets is never selected.
- R5: With `cfgMode`=1 (medium), the line is 16 bytes and the set index is `addr[8:4]`. The code 3 behaves exactly like medium.
- R6: With `cfgMode`=2 (large), the index is as in medium. A lookup or write whose `addr[10]` differs from `bankId` is ignored: it gives no response and changes nothing. The tag compare skips address bit 10.
- R7: A write with `wrKind`=0 (fill) stores `wrAddr[35:9]` as the tag and `wrState` in both state copies. It writes way `wrWay` of the set that `wrAddr` selects under the current mode.
- R8: A write with `wrKind`=1 (state update) sets both state copies and leaves the tag unchanged.
- R9: A write with `wrKind`=2 sets only the primary state copy. A write with `wrKind`=3 has no effect.
- R10: `respStateErr` is high with a response when some way whose tag matches holds two state copies that differ.
- R11: Each set keeps a 3-bit tree pseudo-LRU. Bit 0 picks the half: 1 means ways 2..3, 0 means ways 0..1. Bit 1 picks within ways 0..1 and bit 2 picks within ways 2..3. A hit or a fill on a way points those bits away from it. `respVictim` reports the victim computed before the update caused by that same lookup.
- R12: After reset every line is Invalid, every pseudo-LRU value is 0 (victim way 0) and `respValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup strobe |
| reqAddr | input | 36 | Lookup physical address |
| wrEn | input | 1 | Write strobe |
| wrKind | input | 2 | 0 fill, 1 state update, 2 primary copy only, 3 no-op |
| wrAddr | input | 36 | Write physical address |
| wrWay | input | 2 | Way to write |
| wrState | input | 2 | MESI state to write |
| cfgMode | input | 2 | 0 small, 1 medium, 2 large, 3 as medium |
| bankId | input | 1 | Which half of a large pair this slice serves |
| respValid | output | 1 | Lookup result valid |
| respHit | output | 1 | A way hit |
| respWay | output | 2 | Hitting way |
| respState | output | 2 | State of the hitting line |
| respVictim | output | 2 | Pseudo-LRU victim way of the looked-up set |
| respStateErr | output | 1 | The two state copies of a tag-matching way differ |

## Verification
The hardest case to reach is a disagreement between the two state copies. Every normal write keeps the copies equal, so the bench uses the primary-only write kind to corrupt one copy on a live line, then looks the line up to see the error flag. A later state update must clear that flag again. The bank-bit masking in the large arrangement is also hard to reach. For it, a line is filled in medium mode with the bank bit set, the mode is switched, and the line is then looked up with the bank bit cleared. The same steps cover an access to the other bank being dropped, for both reads and writes. A scoreboard model of tags, states and tree bits predicts every response, including the victim sequence after all four ways of one set are filled and hit in a mixed order.

// File: rtl/tagLookupPkg.sv
package tagLookupPkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int ST_W  = 2;
  localparam int OFF_W = 4;

  localparam logic [ST_W-1:0] ST_INVALID = 2'd0;

  typedef enum logic [1:0] {
    MODE_SMALL = 2'd0,
    MODE_MED   = 2'd1,
    MODE_LARGE = 2'd2,
    MODE_ALT   = 2'd3
  } cacheMode_e;

  typedef enum logic [1:0] {
    WR_FILL    = 2'd0,
    WR_STATE   = 2'd1,
    WR_PRIMARY = 2'd2,
    WR_NOP     = 2'd3
  } wrKind_e;

  typedef struct packed {
    logic lookupEn;
    logic wrTagEn;
    logic wrPriEn;
    logic wrSecEn;
  } ctlStrobes_t;

  // tree: bit0 half (1 = ways 2..3), bit1 inside 0..1, bit2 inside 2..3
  function automatic logic [2:0] plruTouch(input logic [2:0] cur, input logic [WAY_W-1:0] way);
    logic [2:0] nxt;
    nxt = cur;
    nxt[0] = ~way[1];
    if (!way[1]) nxt[1] = ~way[0];
    else         nxt[2] = ~way[0];
    return nxt;
  endfunction

  function automatic logic [WAY_W-1:0] plruVictim(input logic [2:0] cur);
    return cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
  endfunction

endpackage

// File: rtl/tagLookupCtrl.sv
module tagLookupCtrl import tagLookupPkg::*; #(
  parameter int ADDR_W = 36,
  parameter int IDX_W  = 5,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        cfgMode,
  input  logic              bankId,
  output ctlStrobes_t       ctl,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [TAG_W-1:0]  lkTag,
  output logic [TAG_W-1:0]  wrTag,
  output logic [TAG_W-1:0]  cmpMask
);

  localparam int TAG_LO   = OFF_W + IDX_W;
  localparam int BANK_BIT = TAG_LO + 1;

  cacheMode_e mode;
  wrKind_e    kind;
  logic       lkServed, wrServed, wrGo;
  logic       unusedOffsetBits;

  assign mode = cacheMode_e'(cfgMode);
  assign kind = wrKind_e'(wrKind);

  function automatic logic [IDX_W-1:0] setOf(input logic [ADDR_W-1:0] addr, input cacheMode_e m);
    if (m == MODE_SMALL) return {1'b0, addr[OFF_W+1 +: IDX_W-1]};
    else                 return addr[OFF_W +: IDX_W];
  endfunction

  function automatic logic bankMatch(input logic [ADDR_W-1:0] addr, input cacheMode_e m, input logic bank);
    return (m != MODE_LARGE) || (addr[BANK_BIT] == bank);
  endfunction

  always_comb begin
    lkServed = bankMatch(reqAddr, mode, bankId);
    wrServed = bankMatch(wrAddr, mode, bankId);
    wrGo     = wrEn && wrServed;

    lkIdx = setOf(reqAddr, mode);
    wrIdx = setOf(wrAddr, mode);
    lkTag = reqAddr[ADDR_W-1:TAG_LO];
    wrTag = wrAddr[ADDR_W-1:TAG_LO];

    cmpMask = '1;
    if (mode == MODE_LARGE) cmpMask[BANK_BIT-TAG_LO] = 1'b0;

    ctl.lookupEn = reqValid && lkServed;
    ctl.wrTagEn  = wrGo && (kind == WR_FILL);
    ctl.wrPriEn  = wrGo && (kind != WR_NOP);
    ctl.wrSecEn  = wrGo && ((kind == WR_FILL) || (kind == WR_STATE));
  end

  assign unusedOffsetBits = ^{reqAddr[OFF_W-1:0], wrAddr[OFF_W-1:0]};

endmodule

// File: rtl/tagLookupData.sv
module tagLookupData import tagLookupPkg::*; #(
  parameter int IDX_W = 5,
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TAG_W-1:0] lkTag,
  input  logic [TAG_W-1:0] wrTag,
  input  logic [TAG_W-1:0] cmpMask,
  input  logic [WAY_W-1:0] wrWay,
  input  logic [ST_W-1:0]  wrState,
  output logic             respValid,
  output logic             respHit,
  output logic [WAY_W-1:0] respWay,
  output logic [ST_W-1:0]  respState,
  output logic [WAY_W-1:0] respVictim,
  output logic             respStateErr
);

  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tagMem [0:WAYS-1][0:SETS-1];
  logic [ST_W-1:0]  stPri  [0:WAYS-1][0:SETS-1];
  logic [ST_W-1:0]  stSec  [0:WAYS-1][0:SETS-1];
  logic [2:0]       plru   [0:SETS-1];

  logic [WAYS-1:0]  tagEq, wayHit, wayErr;
  logic [ST_W-1:0]  wayState [0:WAYS-1];
  logic             anyHit;
  logic [WAY_W-1:0] hitWay;
  logic [ST_W-1:0]  hitState;
  logic [2:0]       curPlru;

  // parallel compare of every way
  for (genvar w = 0; w < WAYS; w++) begin : gWay
    logic [TAG_W-1:0] rdTag;
    logic [ST_W-1:0]  rdPri, rdSec;
    assign rdTag       = tagMem[w][lkIdx];
    assign rdPri       = stPri[w][lkIdx];
    assign rdSec       = stSec[w][lkIdx];
    assign tagEq[w]    = ((rdTag ^ lkTag) & cmpMask) == '0;
    assign wayHit[w]   = tagEq[w] && (rdPri != ST_INVALID);
    assign wayErr[w]   = tagEq[w] && (rdPri != rdSec);
    assign wayState[w] = rdPri;
  end

  always_comb begin
    anyHit   = |wayHit;
    hitWay   = '0;
    hitState = ST_INVALID;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) begin
        hitWay   = WAY_W'(w);
        hitState = wayState[w];
      end
    end
    curPlru = plru[lkIdx];
  end

  // tag array: contents only matter once a state is valid
  always_ff @(posedge clk) begin
    if (ctl.wrTagEn) tagMem[wrWay][wrIdx] <= wrTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int s = 0; s < SETS; s++) begin
          stPri[w][s] <= ST_INVALID;
          stSec[w][s] <= ST_INVALID;
        end
      end
    end else begin
      if (ctl.wrPriEn) stPri[wrWay][wrIdx] <= wrState;
      if (ctl.wrSecEn) stSec[wrWay][wrIdx] <= wrState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) plru[s] <= '0;
    end else begin
      if (ctl.lookupEn && anyHit) plru[lkIdx] <= plruTouch(curPlru, hitWay);
      if (ctl.wrTagEn)            plru[wrIdx] <= plruTouch(plru[wrIdx], wrWay);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      respHit      <= 1'b0;
      respWay      <= '0;
      respState    <= ST_INVALID;
      respVictim   <= '0;
      respStateErr <= 1'b0;
    end else begin
      respValid    <= ctl.lookupEn;
      respHit      <= anyHit;
      respWay      <= hitWay;
      respState    <= hitState;
      respVictim   <= plruVictim(curPlru);
      respStateErr <= ctl.lookupEn && (|wayErr);
    end
  end

endmodule

// File: rtl/tagLookupTop.sv
module tagLookupTop import tagLookupPkg::*; #(
  parameter int ADDR_W = 36,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrWay,
  input  logic [1:0]        wrState,
  input  logic [1:0]        cfgMode,
  input  logic              bankId,
  output logic              respValid,
  output logic              respHit,
  output logic [1:0]        respWay,
  output logic [1:0]        respState,
  output logic [1:0]        respVictim,
  output logic              respStateErr
);

  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  ctlStrobes_t      ctl;
  logic [IDX_W-1:0] lkIdx, wrIdx;
  logic [TAG_W-1:0] lkTag, wrTag, cmpMask;

  tagLookupCtrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .reqValid(reqValid), .reqAddr(reqAddr), .wrEn(wrEn), .wrKind(wrKind),
    .wrAddr(wrAddr), .cfgMode(cfgMode), .bankId(bankId), .ctl(ctl),
    .lkIdx(lkIdx), .wrIdx(wrIdx), .lkTag(lkTag), .wrTag(wrTag), .cmpMask(cmpMask)
  );

  tagLookupData #(.IDX_W(IDX_W), .TAG_W(TAG_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lkIdx(lkIdx), .wrIdx(wrIdx),
    .lkTag(lkTag), .wrTag(wrTag), .cmpMask(cmpMask), .wrWay(wrWay), .wrState(wrState),
    .respValid(respValid), .respHit(respHit), .respWay(respWay), .respState(respState),
    .respVictim(respVictim), .respStateErr(respStateErr)
  );

endmodule

// File: rtl/tagLookupChecker.sv
module tagLookupChecker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqBankBit,
  input logic [1:0] cfgMode,
  input logic       bankId,
  input logic       respValid,
  input logic       respHit,
  input logic [1:0] respWay,
  input logic [1:0] respState,
  input logic       respStateErr
);

  AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(reqValid)); // R1

  AST_HIT_NOT_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> (respState != 2'd0)); // R2

  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respWay == 2'd0 && respState == 2'd0)); // R3

  AST_OTHER_BANK_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cfgMode == 2'd2 && reqBankBit != bankId) |=> !respValid); // R6

  AST_ERR_WITH_RESP: assert property (@(posedge clk) disable iff (!rstN)
    respStateErr |-> respValid); // R10

endmodule

bind tagLookupTop tagLookupChecker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBankBit(reqAddr[IDX_W+5]),
  .cfgMode(cfgMode), .bankId(bankId), .respValid(respValid), .respHit(respHit),
  .respWay(respWay), .respState(respState), .respStateErr(respStateErr)
);

// File: tb/tb_tagLookupTop.sv
`timescale 1ns/1ps
module tb_tagLookupTop;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, wrEn, bankId;
  logic [35:0] reqAddr, wrAddr;
  logic [1:0]  wrKind, wrWay, wrState, cfgMode;
  logic        respValid, respHit, respStateErr;
  logic [1:0]  respWay, respState, respVictim;

  always #2.5 clk = ~clk;

  tagLookupTop dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .wrEn(wrEn),
    .wrKind(wrKind), .wrAddr(wrAddr), .wrWay(wrWay), .wrState(wrState),
    .cfgMode(cfgMode), .bankId(bankId), .respValid(respValid), .respHit(respHit),
    .respWay(respWay), .respState(respState), .respVictim(respVictim),
    .respStateErr(respStateErr)
  );

  typedef struct {
    logic       hit;
    logic [1:0] way;
    logic [1:0] st;
    logic [1:0] vic;
    logic       err;
    string      req;
  } expItem_t;

  expItem_t    expQ[$];
  logic [26:0] mTag [0:3][0:31];
  logic [1:0]  mA   [0:3][0:31];
  logic [1:0]  mB   [0:3][0:31];
  logic [2:0]  mP   [0:31];
  int checks = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [35:0] mk(input logic [26:0] tag, input logic [4:0] set, input logic [3:0] off);
    return {tag, set, off};
  endfunction

  function automatic int mIdx(input logic [35:0] a);
    return (cfgMode == 2'd0) ? int'({1'b0, a[8:5]}) : int'(a[8:4]);
  endfunction

  function automatic bit mServed(input logic [35:0] a);
    return (cfgMode != 2'd2) || (a[10] == bankId);
  endfunction

  function automatic logic [2:0] mTouch(input logic [2:0] p, input int w);
    logic [2:0] n;
    n = p;
    if (w < 2) begin n[0] = 1'b1; n[1] = (w == 0); end
    else       begin n[0] = 1'b0; n[2] = (w == 2); end
    return n;
  endfunction

  function automatic logic [1:0] mVictim(input logic [2:0] p);
    if (p[0]) return p[2] ? 2'd3 : 2'd2;
    return p[1] ? 2'd1 : 2'd0;
  endfunction

  task automatic doWrite(input logic [1:0] kind, input logic [1:0] way, input logic [35:0] a, input logic [1:0] st);
    int s;
    s = mIdx(a);
    if (mServed(a)) begin
      case (kind)
        2'd0: begin mTag[way][s] = a[35:9]; mA[way][s] = st; mB[way][s] = st; mP[s] = mTouch(mP[s], int'(way)); end
        2'd1: begin mA[way][s] = st; mB[way][s] = st; end
        2'd2: mA[way][s] = st;
        default: ;
      endcase
    end
    wrEn = 1'b1; wrKind = kind; wrWay = way; wrAddr = a; wrState = st;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doLookup(input logic [35:0] a, input string req);
    expItem_t it;
    int s;
    logic [26:0] mask;
    s = mIdx(a);
    mask = '1;
    if (cfgMode == 2'd2) mask[1] = 1'b0;
    if (mServed(a)) begin
      it.hit = 1'b0; it.way = 2'd0; it.st = 2'd0; it.err = 1'b0; it.req = req;
      it.vic = mVictim(mP[s]);
      for (int w = 3; w >= 0; w--) begin
        if (((mTag[w][s] ^ a[35:9]) & mask) == 27'd0) begin
          if (mA[w][s] != mB[w][s]) it.err = 1'b1;
          if (mA[w][s] != 2'd0) begin it.hit = 1'b1; it.way = 2'(w); it.st = mA[w][s]; end
        end
      end
      if (it.hit) mP[s] = mTouch(mP[s], int'(it.way));
      expQ.push_back(it);
    end
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compare each response with the oldest prediction
  initial begin
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && respValid === 1'b1) begin
        checks++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R1 unexpected response: got respValid=1 expected 0");
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (respHit !== it.hit || respWay !== it.way || respState !== it.st ||
              respVictim !== it.vic || respStateErr !== it.err) begin
            bad++;
            $display("FAIL %s: got hit=%0d way=%0d st=%0d vic=%0d err=%0d expected hit=%0d way=%0d st=%0d vic=%0d err=%0d",
                     it.req, respHit, respWay, respState, respVictim, respStateErr,
                     it.hit, it.way, it.st, it.vic, it.err);
          end
        end
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL R1 watchdog expired: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 32; s++) begin mTag[w][s] = '0; mA[w][s] = '0; mB[w][s] = '0; end
    for (int s = 0; s < 32; s++) mP[s] = '0;
    rstN = 1'b0; reqValid = 1'b0; wrEn = 1'b0; reqAddr = '0; wrAddr = '0;
    wrKind = 2'd0; wrWay = 2'd0; wrState = 2'd0; cfgMode = 2'd1; bankId = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (respValid !== 1'b0) begin
      bad++;
      $display("FAIL R12 reset: got respValid=%0d expected 0", respValid);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R12 R3: empty array misses, victim way 0
    doLookup(mk(27'h123, 5'd3, 4'h0), "R12 R3 empty lookup");

    // R7 R2 R5: fill and hit in medium mode
    doWrite(2'd0, 2'd2, mk(27'h1234, 5'd6, 4'h0), 2'd2);
    doLookup(mk(27'h1234, 5'd6, 4'h9), "R7 R2 R5 fill hit");
    doLookup(mk(27'h1234, 5'd7, 4'h0), "R5 neighbour set miss");
    cfgMode = 2'd3;
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R5 code 3 as medium");
    cfgMode = 2'd1;

    // R8 R3: state-only updates keep the tag
    doWrite(2'd1, 2'd2, mk(27'h1234, 5'd6, 4'h0), 2'd3);
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R8 state to modified");
    doWrite(2'd1, 2'd2, mk(27'h1234, 5'd6, 4'h0), 2'd0);
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R3 R8 invalid line misses");
    doWrite(2'd1, 2'd2, mk(27'h1234, 5'd6, 4'h0), 2'd1);
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R8 tag kept");

    // R9 R10: single-copy write and no-op
    doWrite(2'd2, 2'd2, mk(27'h1234, 5'd6, 4'h0), 2'd3);
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R9 R10 copies differ");
    doWrite(2'd1, 2'd2, mk(27'h1234, 5'd6, 4'h0), 2'd1);
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R10 error cleared");
    doWrite(2'd3, 2'd2, mk(27'h1234, 5'd6, 4'h0), 2'd0);
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R9 no-op write");

    // R4: small mode, 32-byte line
    cfgMode = 2'd0;
    doWrite(2'd0, 2'd1, mk(27'h0AB, 5'd8, 4'h0), 2'd1);
    doLookup(mk(27'h0AB, 5'd9, 4'h7), "R4 same 32-byte line");
    doLookup(mk(27'h0AB, 5'd10, 4'h0), "R4 other small set");
    cfgMode = 2'd1;
    doLookup(mk(27'h0AB, 5'd8, 4'h0), "R4 R5 medium set 8 separate");
    doLookup(mk(27'h0AB, 5'd4, 4'h0), "R4 R5 small set shares lower half");

    // R11: fill all ways of one set, then hit in mixed order
    for (int w = 0; w < 4; w++) doWrite(2'd0, 2'(w), mk(27'h100 + 27'(w), 5'd12, 4'h0), 2'd1);
    doLookup(mk(27'h101, 5'd12, 4'h0), "R11 hit way1");
    doLookup(mk(27'h103, 5'd12, 4'h0), "R11 hit way3");
    doLookup(mk(27'h100, 5'd12, 4'h0), "R11 hit way0");
    doLookup(mk(27'h555, 5'd12, 4'h0), "R11 miss shows victim");

    // R6: large mode bank select and mask
    bankId = 1'b0;
    doWrite(2'd0, 2'd0, mk(27'h402, 5'd20, 4'h0), 2'd3);
    cfgMode = 2'd2;
    doLookup(mk(27'h400, 5'd20, 4'h0), "R6 bank bit masked");
    doLookup(mk(27'h402, 5'd20, 4'h0), "R6 other bank ignored");
    doWrite(2'd0, 2'd0, mk(27'h7FE, 5'd20, 4'h0), 2'd1);
    doLookup(mk(27'h400, 5'd20, 4'h0), "R6 other bank write ignored");
    bankId = 1'b1;
    doLookup(mk(27'h402, 5'd20, 4'h0), "R6 bank one served");
    bankId = 1'b0;
    cfgMode = 2'd1;

    // R1: back-to-back lookups
    doLookup(mk(27'h1234, 5'd6, 4'h0), "R1 burst 1");
    doLookup(mk(27'h102, 5'd12, 4'h0), "R1 burst 2");
    doLookup(mk(27'h999, 5'd1, 4'h0), "R1 burst 3");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R1 missing responses: got %0d pending expected 0", expQ.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule